// File: doc/BRIEF.md
# Extended-Address Bus Cycle Sequencer

This block drives the bus of an 8-bit processor core while it runs instructions that carry a full 16-bit absolute operand address inside the instruction stream. Each clock is one bus cycle. In every cycle the block presents an address, a read/write strobe and, in write cycles, a data byte. It also samples the byte that memory returns. The block first reads the opcode, or a page-select prebyte followed by a second opcode byte. It then collects the high and low bytes of the operand address and performs the operand accesses, with dummy reads placed exactly where the real bus shows them.

The surrounding core supplies the register value to be stored (`storeWord`) and the modified byte of a read-modify-write (`aluByte`). The sequencer handles only addressing and timing: jumps, 8-bit and 16-bit loads and stores, read-modify-write, test, and 16-bit add/subtract/compare. The `opFetch` output marks the first bus cycle of every instruction, so the core can align its decode to it.

Top module: `xseq_bus`

## Requirements
- R1: While `rst` is high at a clock edge, the block restarts. In the cycle after that edge it presents an opcode fetch: `addr` equals `rstPc`, `rdWr` is 1, `wrData` is 0, `opFetch` is 1 and `pc` equals `rstPc`.
- R2: Opcode $7E (jump) lasts 3 cycles: reads at opcode address, +1 (target high byte) and +2 (target low byte). The next opcode fetch is at the assembled target.
- R3: Any opcode not named in another requirement is an 8-bit read. It lasts 4 cycles: reads at opcode address, +1 and +2, then a read at the operand address formed from those two bytes, high byte first.
- R4: Opcodes $B7 and $F7 (8-bit store) last 4 cycles. The 4th cycle writes `storeWord[7:0]` to the operand address with `rdWr` = 0.
- R5: Opcodes $FC, $BE and $FE (16-bit load) last 5 cycles. Cycle 4 reads the operand address and cycle 5 reads operand address + 1, modulo 2^16.
- R6: Opcodes $FD, $BF and $FF (16-bit store) last 5 cycles. Cycle 4 writes `storeWord[15:8]` to the operand address and cycle 5 writes `storeWord[7:0]` to operand address + 1.
- R7: Prebyte $18 adds one cycle that reads the second opcode byte at opcode address + 1. The address bytes then come from +2 and +3. A second byte of $FF selects the 16-bit store pattern of R6; any other second byte selects the load pattern of R5. Each form lasts 6 cycles.
- R8: Opcodes $70–$7F other than $7D and $7E (read-modify-write) last 6 cycles. Cycle 4 reads the operand address, cycle 5 reads $FFFF, and cycle 6 writes `aluByte` to the operand address.
- R9: Opcode $7D (test) lasts 6 cycles: a read at the operand address, then two reads at $FFFF, with no write.
- R10: Opcodes $B3, $F3 and $BC (16-bit arithmetic/compare) last 6 cycles: reads at the operand address and operand address + 1, then a read at $FFFF.
- R11: Except after a jump, the next opcode fetch is at opcode address + 3, or + 4 when a prebyte was present. On every opcode fetch `pc` equals `addr`. `rdWr` is 1 and `wrData` is 0 in every cycle other than the write cycles of R4, R6, R7 and R8.
- R12: `opFetch` is 1 exactly in the first bus cycle of each instruction. It is 0 in the second-opcode-byte cycle of R7, and it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one bus cycle per rising edge |
| rst | input | 1 | Synchronous active-high restart |
| rstPc | input | 16 | Address of the first opcode fetched after restart |
| rdData | input | 8 | Byte returned by memory in the current cycle |
| storeWord | input | 16 | Register value written by store instructions |
| aluByte | input | 8 | Modified byte written back by read-modify-write |
| addr | output | 16 | Bus address of the current cycle |
| rdWr | output | 1 | 1 = read cycle, 0 = write cycle |
| wrData | output | 8 | Byte driven in write cycles, 0 otherwise |
| opFetch | output | 1 | High in the opcode fetch cycle of each instruction |
| pc | output | 16 | Program counter |

## Verification
A behavioural model in the bench expands a fixed program into an expected per-cycle list of address, strobe, write byte and fetch marker, and the outputs are compared against it on every cycle. The program places one instruction of each class back to back. A mismatch in any single instruction's length or dummy-cycle placement therefore shifts every later fetch and shows up at once. Operand addresses whose low byte is $FF, and an operand address of $FFFF, separate a correct 16-bit carry and wrap from an 8-bit one. A loop-closing jump shows that the target is taken, not the fall-through address. A restart in the middle of an instruction, with new `storeWord` and `aluByte` values and a different `rstPc`, shows that no instruction state survives reset and that the write data tracks its inputs.

// File: rtl/xseq_pkg.sv
package xseq_pkg;

  localparam logic [7:0] OPC_PAGE2  = 8'h18;
  localparam logic [7:0] OPC_JUMP   = 8'h7E;
  localparam logic [7:0] OPC_TEST   = 8'h7D;
  localparam logic [7:0] OPC_Y_STORE = 8'hFF;

  typedef enum logic [2:0] {
    PH_FETCH, PH_PAGE2, PH_ADRH, PH_ADRL, PH_OP1, PH_OP2, PH_OP3
  } phase_t;

  typedef enum logic [3:0] {
    K_READ8, K_STORE8, K_LOAD16, K_STORE16,
    K_RMW, K_TEST, K_ARITH, K_JUMP, K_PREBYTE
  } kind_t;

  typedef enum logic [1:0] { A_PC, A_EA, A_EA1, A_IDLE } addrSel_t;
  typedef enum logic [1:0] { W_NONE, W_HI, W_LO, W_ALU } wrSel_t;

  typedef struct packed {
    addrSel_t addrSel;
    logic     write;
    wrSel_t   wrSel;
    logic     pcInc;
    logic     capHi;
    logic     capLo;
    logic     jump;
  } strobe_t;

  function automatic kind_t classifyOp(input logic [7:0] op);
    kind_t k;
    case (op)
      OPC_PAGE2:          k = K_PREBYTE;
      OPC_JUMP:           k = K_JUMP;
      OPC_TEST:           k = K_TEST;
      8'hB7, 8'hF7:       k = K_STORE8;
      8'hFC, 8'hBE, 8'hFE: k = K_LOAD16;
      8'hFD, 8'hBF, 8'hFF: k = K_STORE16;
      8'hB3, 8'hF3, 8'hBC: k = K_ARITH;
      default:            k = (op[7:4] == 4'h7) ? K_RMW : K_READ8;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/xseq_datapath.sv
module xseq_datapath
  import xseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*DW-1:0] rstPc,
  input  logic [DW-1:0]   rdData,
  input  logic [2*DW-1:0] storeWord,
  input  logic [DW-1:0]   aluByte,
  input  strobe_t         stb,
  output logic [2*DW-1:0] addr,
  output logic [DW-1:0]   wrData,
  output logic [2*DW-1:0] pc
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] pcReg;
  logic [DW-1:0] eaHi, eaLo;
  logic [AW-1:0] ea;

  assign ea = {eaHi, eaLo};
  assign pc = pcReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg <= rstPc;
    end else if (stb.jump) begin
      pcReg <= {eaHi, rdData};
    end else if (stb.pcInc) begin
      pcReg <= pcReg + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eaHi <= '0;
      eaLo <= '0;
    end else begin
      if (stb.capHi) eaHi <= rdData;
      if (stb.capLo) eaLo <= rdData;
    end
  end

  always_comb begin
    case (stb.addrSel)
      A_PC:    addr = pcReg;
      A_EA:    addr = ea;
      A_EA1:   addr = ea + AW'(1);
      default: addr = '1;
    endcase
  end

  always_comb begin
    case (stb.wrSel)
      W_HI:    wrData = storeWord[AW-1:DW];
      W_LO:    wrData = storeWord[DW-1:0];
      W_ALU:   wrData = aluByte;
      default: wrData = '0;
    endcase
  end

  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == $past(rstPc));

endmodule

// File: rtl/xseq_control.sv
module xseq_control
  import xseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rdData,
  output strobe_t       stb,
  output logic          opFetch
);
  phase_t phase, phaseNext;
  kind_t  kind, kindNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      kind  <= K_READ8;
    end else begin
      phase <= phaseNext;
      kind  <= kindNext;
    end
  end

  assign opFetch = (phase == PH_FETCH);

  always_comb begin
    stb       = '0;
    stb.addrSel = A_PC;
    stb.wrSel   = W_NONE;
    phaseNext = phase;
    kindNext  = kind;
    case (phase)
      PH_FETCH: begin
        stb.pcInc = 1'b1;
        kindNext  = classifyOp(rdData);
        phaseNext = (kindNext == K_PREBYTE) ? PH_PAGE2 : PH_ADRH;
      end
      PH_PAGE2: begin
        stb.pcInc = 1'b1;
        kindNext  = (rdData == OPC_Y_STORE) ? K_STORE16 : K_LOAD16;
        phaseNext = PH_ADRH;
      end
      PH_ADRH: begin
        stb.pcInc = 1'b1;
        stb.capHi = 1'b1;
        phaseNext = PH_ADRL;
      end
      PH_ADRL: begin
        stb.capLo = 1'b1;
        if (kind == K_JUMP) begin
          stb.jump  = 1'b1;
          phaseNext = PH_FETCH;
        end else begin
          stb.pcInc = 1'b1;
          phaseNext = PH_OP1;
        end
      end
      PH_OP1: begin
        stb.addrSel = A_EA;
        if (kind == K_STORE8) begin
          stb.write = 1'b1;
          stb.wrSel = W_LO;
        end else if (kind == K_STORE16) begin
          stb.write = 1'b1;
          stb.wrSel = W_HI;
        end
        phaseNext = (kind == K_READ8 || kind == K_STORE8) ? PH_FETCH : PH_OP2;
      end
      PH_OP2: begin
        stb.addrSel = (kind == K_RMW || kind == K_TEST) ? A_IDLE : A_EA1;
        if (kind == K_STORE16) begin
          stb.write = 1'b1;
          stb.wrSel = W_LO;
        end
        phaseNext = (kind == K_LOAD16 || kind == K_STORE16) ? PH_FETCH : PH_OP3;
      end
      PH_OP3: begin
        if (kind == K_RMW) begin
          stb.addrSel = A_EA;
          stb.write   = 1'b1;
          stb.wrSel   = W_ALU;
        end else begin
          stb.addrSel = A_IDLE;
        end
        phaseNext = PH_FETCH;
      end
      default: phaseNext = PH_FETCH;
    endcase
  end

  // R12
  fetch_gap_chk: assert property (@(posedge clk) disable iff (rst)
    opFetch |=> !opFetch);

  // R2
  jump_len_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADRL && kind == K_JUMP) |=> opFetch);

  // R9
  test_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OP3 && kind == K_TEST) |-> !stb.write);

endmodule

// File: rtl/xseq_bus.sv
module xseq_bus
  import xseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*DW-1:0] rstPc,
  input  logic [DW-1:0]   rdData,
  input  logic [2*DW-1:0] storeWord,
  input  logic [DW-1:0]   aluByte,
  output logic [2*DW-1:0] addr,
  output logic            rdWr,
  output logic [DW-1:0]   wrData,
  output logic            opFetch,
  output logic [2*DW-1:0] pc
);
  strobe_t stb;

  xseq_control #(.DW(DW)) u_control (
    .clk(clk), .rst(rst), .rdData(rdData), .stb(stb), .opFetch(opFetch)
  );

  xseq_datapath #(.DW(DW)) u_datapath (
    .clk(clk), .rst(rst), .rstPc(rstPc), .rdData(rdData),
    .storeWord(storeWord), .aluByte(aluByte), .stb(stb),
    .addr(addr), .wrData(wrData), .pc(pc)
  );

  assign rdWr = !stb.write;

  // R11
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rdWr |-> wrData == '0);

  // R1
  reset_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (opFetch && rdWr && addr == $past(rstPc)));

  // R11
  fetch_pc_chk: assert property (@(posedge clk) disable iff (rst)
    opFetch |-> addr == pc);

endmodule

// File: tb/xseq_bus_bench.sv
module xseq_bus_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] rstPc;
  logic [7:0]  rdData;
  logic [15:0] storeW;
  logic [7:0]  alu;
  logic [15:0] addr;
  logic        rdWr;
  logic [7:0]  wrData;
  logic        opFetch;
  logic [15:0] pc;

  always #5 clk = ~clk;

  xseq_bus u_xseq_bus (
    .clk(clk), .rst(rst), .rstPc(rstPc), .rdData(rdData),
    .storeWord(storeW), .aluByte(alu), .addr(addr), .rdWr(rdWr),
    .wrData(wrData), .opFetch(opFetch), .pc(pc)
  );

  typedef struct {
    logic [15:0] a;
    logic        rw;
    logic [7:0]  wd;
    logic        f;
    string       tag;
  } cyc_t;

  cyc_t        expQ[$];
  logic [7:0]  prog[0:63];
  logic [15:0] modelPc;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  function automatic logic [7:0] mem(input logic [15:0] a);
    int idx = int'(a) - 32'h1000;
    if (idx >= 0 && idx < 64) return prog[idx];
    return a[7:0] ^ a[15:8];
  endfunction

  always_comb rdData = mem(addr);

  task automatic push(input logic [15:0] a, input logic rw,
                      input logic [7:0] wd, input logic f, input string tag);
    cyc_t c;
    c.a = a; c.rw = rw; c.wd = wd; c.f = f; c.tag = tag;
    expQ.push_back(c);
  endtask

  task automatic expand();
    logic [7:0]  op, op2;
    logic [15:0] ea;
    op = mem(modelPc);
    push(modelPc, 1'b1, 8'h00, 1'b1, "R11");
    if (op == 8'h18) begin
      op2 = mem(modelPc + 16'd1);
      push(modelPc + 16'd1, 1'b1, 8'h00, 1'b0, "R7");
      push(modelPc + 16'd2, 1'b1, 8'h00, 1'b0, "R7");
      push(modelPc + 16'd3, 1'b1, 8'h00, 1'b0, "R7");
      ea = {mem(modelPc + 16'd2), mem(modelPc + 16'd3)};
      if (op2 == 8'hFF) begin
        push(ea, 1'b0, storeW[15:8], 1'b0, "R7");
        push(ea + 16'd1, 1'b0, storeW[7:0], 1'b0, "R7");
      end else begin
        push(ea, 1'b1, 8'h00, 1'b0, "R7");
        push(ea + 16'd1, 1'b1, 8'h00, 1'b0, "R7");
      end
      modelPc = modelPc + 16'd4;
      return;
    end
    ea = {mem(modelPc + 16'd1), mem(modelPc + 16'd2)};
    push(modelPc + 16'd1, 1'b1, 8'h00, 1'b0, "R11");
    push(modelPc + 16'd2, 1'b1, 8'h00, 1'b0, "R11");
    modelPc = modelPc + 16'd3;
    if (op == 8'h7E) begin
      modelPc = ea;                                              // R2
    end else if (op == 8'h7D) begin
      push(ea, 1'b1, 8'h00, 1'b0, "R9");
      push(16'hFFFF, 1'b1, 8'h00, 1'b0, "R9");
      push(16'hFFFF, 1'b1, 8'h00, 1'b0, "R9");
    end else if (op[7:4] == 4'h7) begin
      push(ea, 1'b1, 8'h00, 1'b0, "R8");
      push(16'hFFFF, 1'b1, 8'h00, 1'b0, "R8");
      push(ea, 1'b0, alu, 1'b0, "R8");
    end else if (op == 8'hB7 || op == 8'hF7) begin
      push(ea, 1'b0, storeW[7:0], 1'b0, "R4");
    end else if (op == 8'hFC || op == 8'hBE || op == 8'hFE) begin
      push(ea, 1'b1, 8'h00, 1'b0, "R5");
      push(ea + 16'd1, 1'b1, 8'h00, 1'b0, "R5");
    end else if (op == 8'hFD || op == 8'hBF || op == 8'hFF) begin
      push(ea, 1'b0, storeW[15:8], 1'b0, "R6");
      push(ea + 16'd1, 1'b0, storeW[7:0], 1'b0, "R6");
    end else if (op == 8'hB3 || op == 8'hF3 || op == 8'hBC) begin
      push(ea, 1'b1, 8'h00, 1'b0, "R10");
      push(ea + 16'd1, 1'b1, 8'h00, 1'b0, "R10");
      push(16'hFFFF, 1'b1, 8'h00, 1'b0, "R10");
    end else begin
      push(ea, 1'b1, 8'h00, 1'b0, "R3");
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic stepCompare();
    cyc_t e;
    if (expQ.size() == 0) expand();
    e = expQ.pop_front();
    check(addr === e.a, e.tag, "addr", addr, e.a);
    check(rdWr === e.rw, e.tag, "rdWr", {15'd0, rdWr}, {15'd0, e.rw});
    check(wrData === e.wd, e.tag, "wrData", {8'd0, wrData}, {8'd0, e.wd});
    check(opFetch === e.f, "R12", "opFetch", {15'd0, opFetch}, {15'd0, e.f});
    if (e.f) check(pc === e.a, "R11", "pc", pc, e.a);
  endtask

  task automatic checkReset();
    check(addr === rstPc, "R1", "addr", addr, rstPc);
    check(opFetch === 1'b1, "R1", "opFetch", {15'd0, opFetch}, 16'd1);
    check(rdWr === 1'b1, "R1", "rdWr", {15'd0, rdWr}, 16'd1);
    check(wrData === 8'h00, "R1", "wrData", {8'd0, wrData}, 16'd0);
    check(pc === rstPc, "R1", "pc", pc, rstPc);
  endtask

  task automatic runFrom(input logic [15:0] start, input int n);
    expQ.delete();
    modelPc = start;
    rst = 1'b0;
    stepCompare();
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      stepCompare();
    end
  endtask

  initial begin
    logic [7:0] img[0:43];
    img = '{8'hB6,8'h20,8'h00, 8'hB7,8'h20,8'h10, 8'hFC,8'h21,8'h00,
            8'hFD,8'h21,8'h10, 8'h18,8'hFE,8'h22,8'h00,
            8'h18,8'hFF,8'h22,8'h10, 8'h7C,8'h23,8'h00,
            8'h7D,8'h23,8'h10, 8'hF3,8'h24,8'h00, 8'hBC,8'h24,8'hFF,
            8'hBE,8'h20,8'hFF, 8'hFE,8'hFF,8'hFF, 8'h7F,8'h25,8'h00,
            8'h7E,8'h10,8'h00};
    for (int i = 0; i < 64; i++) prog[i] = (i < 44) ? img[i] : 8'h01;
    rst = 1'b1;
    rstPc = 16'h1000;
    storeW = 16'hC3A7;
    alu = 8'h5E;
    repeat (3) begin
      @(negedge clk);
      checkReset();
    end
    runFrom(16'h1000, 160);
    @(negedge clk);
    rst = 1'b1;
    rstPc = 16'h1006;
    storeW = 16'h0FF1;
    alu = 8'hA2;
    repeat (2) begin
      @(negedge clk);
      checkReset();
    end
    runFrom(16'h1006, 120);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule